// File: doc/BRIEF.md
# Dithered Fractional PWM Timer

This block is a single-channel pulse-width modulator driven by an up-counter. A period word sets the length of each PWM cycle and a compare word sets how long the output stays high. Either word can carry a fraction in its low bits. The fraction counts how many cycles, out of a frame of 16, 32 or 64 PWM cycles, receive one extra clock. The average period or pulse width therefore has a resolution finer than one clock, while every single cycle stays within one clock of the integer setting.

The extra clocks are not grouped at the start of the frame. A position-times-count test spreads them evenly across the frame, which keeps the low-frequency ripple in the filtered output small. New settings are written into a holding stage with a load strobe and move into the working registers only on the last clock of a PWM cycle. A one-clock cycle-end pulse marks each counter wrap, so a consumer can time the cycles and frames.

Top module: `dither_pwm`

## Requirements
- R1: `mode_i` selects the dither frame: 0 means no dithering, 1 means 16 cycles (4 fraction bits), 2 means 32 cycles (5 fraction bits) and 3 means 64 cycles (6 fraction bits).
- R2: In a dither mode, the low 4, 5 or 6 bits of each word are its fraction count d, and the bits above them are its integer part. With d = 0, no cycle in the frame is lengthened.
- R3: With mode 0, every cycle lasts exactly period+1 clocks and is high for exactly compare clocks, using the full words.
- R4: Let c be the frame index of a cycle and M the mode's mask (15, 31 or 63). That cycle gains one extra clock for a word exactly when ((c·d) AND M) + d > M.
- R5: A cycle lasts P+1+e clocks, where P is the integer period and e is the period's extra bit. Any N consecutive cycles total N·(P+1)+d clocks.
- R6: A cycle is high for C+e' clocks, where C is the integer compare and e' is the compare's extra bit. Any N consecutive cycles total N·C+d high clocks, provided that C < P.
- R7: When the period's fraction is 0, every cycle length equals P+1, even if the compare word carries a fraction.
- R8: The frame index runs from 0 to N−1 and advances at each cycle end. It returns to 0 on reset, and also at a cycle end that brings in a different mode.
- R9: `load_i` captures the mode, period and compare inputs into a holding stage. Held values move into use only at the end of the running cycle, so a cycle already in progress keeps its settings.
- R10: `cyc_end_o` is high for exactly the last clock of each cycle, and the counter restarts at 0 on the next clock.
- R11: While reset is active, the settings are period 0, compare 0 and mode 0. As a result `pwm_o` is low and `cyc_end_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Dither frame select (0 off, 1/2/3 = 16/32/64 cycles) |
| per_i | input | CNT_W | Period word: integer part and fraction |
| cmp_i | input | CNT_W | Compare word: integer part and fraction |
| load_i | input | 1 | Captures mode, period and compare into the holding stage |
| pwm_o | output | 1 | PWM output |
| cyc_end_o | output | 1 | High on the last clock of each PWM cycle |

## Verification
The main function is run with these settings:
- Undithered words.
- Period-only, compare-only and combined fractions in all three frame sizes.
- Fractions of 0, 1, half the frame and the maximum.

Frame totals tell a correct fraction split apart from a shifted one. Cycle-by-cycle lengths for one 16-cycle frame check that the extra clocks fall at the positions the R4 rule selects, not just that their count is right. A mode switch made in the middle of a frame shows whether the frame index restarts. A load made in the middle of a long cycle shows whether the running cycle is protected from a partial update.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

   typedef enum logic [1:0] {
      DM_OFF = 2'd0,
      DM_F16 = 2'd1,
      DM_F32 = 2'd2,
      DM_F64 = 2'd3
   } dmode_e;

   localparam int FRAC_W = 6;

   function automatic logic [FRAC_W-1:0] frac_mask(input dmode_e m);
      case (m)
         DM_F16:  frac_mask = 6'h0F;
         DM_F32:  frac_mask = 6'h1F;
         DM_F64:  frac_mask = 6'h3F;
         default: frac_mask = 6'h00;
      endcase
   endfunction

endpackage

// File: rtl/dpwm_split.sv
module dpwm_split
   import dpwm_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0]      word_i,
   input  dmode_e            mode_i,
   output logic [W-1:0]      int_o,
   output logic [FRAC_W-1:0] frac_o
);
   always_comb begin
      case (mode_i)
         DM_F16: begin
            int_o  = word_i >> 4;
            frac_o = {2'b00, word_i[3:0]};
         end
         DM_F32: begin
            int_o  = word_i >> 5;
            frac_o = {1'b0, word_i[4:0]};
         end
         DM_F64: begin
            int_o  = word_i >> 6;
            frac_o = word_i[5:0];
         end
         default: begin
            int_o  = word_i;
            frac_o = '0;
         end
      endcase
   end
endmodule

// File: rtl/dpwm_extra.sv
module dpwm_extra
   import dpwm_pkg::*;
(
   input  dmode_e            mode_i,
   input  logic [FRAC_W-1:0] frac_i,
   input  logic [FRAC_W-1:0] idx_i,
   output logic              extra_o
);
   localparam int PW = 2 * FRAC_W;

   logic [PW-1:0]     prod;
   logic [FRAC_W-1:0] mask;
   logic [FRAC_W:0]   sum;

   always_comb begin
      mask    = frac_mask(mode_i);
      prod    = {{FRAC_W{1'b0}}, idx_i} * {{FRAC_W{1'b0}}, frac_i};
      sum     = {1'b0, prod[FRAC_W-1:0] & mask} + {1'b0, frac_i};
      extra_o = (mode_i != DM_OFF) && (sum > {1'b0, mask});
   end
endmodule

// File: rtl/dpwm_frame.sv
module dpwm_frame
   import dpwm_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  dmode_e            mode_i,
   input  logic              step_i,
   input  logic              clear_i,
   output logic [FRAC_W-1:0] idx_o
);
   logic [FRAC_W-1:0] mask;
   assign mask = frac_mask(mode_i);

   always_ff @(posedge clk) begin
      if (!rst_n)
         idx_o <= '0;
      else if (step_i) begin
         if (clear_i || idx_o >= mask)
            idx_o <= '0;
         else
            idx_o <= idx_o + 1'b1;
      end
   end

   // R8: index never leaves 0..N-1 of the active mode
   p_idx_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      idx_o <= frac_mask(mode_i));

   // R8: a mode change at a cycle end restarts the frame
   p_idx_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && clear_i) |=> idx_o == '0);
endmodule

// File: rtl/dither_pwm.sv
module dither_pwm
   import dpwm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode_i,
   input  logic [CNT_W-1:0] per_i,
   input  logic [CNT_W-1:0] cmp_i,
   input  logic             load_i,
   output logic             pwm_o,
   output logic             cyc_end_o
);
   localparam int LANES = 2;   // lane 0: period, lane 1: compare
   localparam int EW    = CNT_W + 1;

   if (CNT_W < 8) begin : g_bad_width
      $error("dither_pwm: CNT_W must be at least 8");
   end

   dmode_e           mode_buf, mode_act;
   logic [CNT_W-1:0] per_buf, cmp_buf, per_act, cmp_act;
   logic [EW-1:0]    cnt_q;
   logic [FRAC_W-1:0] idx;

   logic [CNT_W-1:0]  word_act [LANES];
   logic [CNT_W-1:0]  int_part [LANES];
   logic [FRAC_W-1:0] frac     [LANES];
   logic [LANES-1:0]  extra;

   logic [EW-1:0] top_eff, cmp_eff;
   logic          wrap;

   assign word_act[0] = per_act;
   assign word_act[1] = cmp_act;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      dpwm_split #(.W(CNT_W)) u_split (
         .word_i (word_act[g]),
         .mode_i (mode_act),
         .int_o  (int_part[g]),
         .frac_o (frac[g])
      );
      dpwm_extra u_extra (
         .mode_i  (mode_act),
         .frac_i  (frac[g]),
         .idx_i   (idx),
         .extra_o (extra[g])
      );
   end

   assign top_eff = {1'b0, int_part[0]} + {{CNT_W{1'b0}}, extra[0]};
   assign cmp_eff = {1'b0, int_part[1]} + {{CNT_W{1'b0}}, extra[1]};
   assign wrap    = (cnt_q == top_eff);

   dpwm_frame u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode_i  (mode_act),
      .step_i  (wrap),
      .clear_i (mode_buf != mode_act),
      .idx_o   (idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_buf <= DM_OFF;
         per_buf  <= '0;
         cmp_buf  <= '0;
      end else if (load_i) begin
         mode_buf <= dmode_e'(mode_i);
         per_buf  <= per_i;
         cmp_buf  <= cmp_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_act <= DM_OFF;
         per_act  <= '0;
         cmp_act  <= '0;
         cnt_q    <= '0;
      end else if (wrap) begin
         mode_act <= mode_buf;
         per_act  <= per_buf;
         cmp_act  <= cmp_buf;
         cnt_q    <= '0;
      end else begin
         cnt_q    <= cnt_q + 1'b1;
      end
   end

   assign pwm_o     = (cnt_q < cmp_eff);
   assign cyc_end_o = wrap;

   // R5: counter stays within the effective top of the running cycle
   p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= top_eff);

   // R9: working settings only change across a cycle end
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_end_o |=> ($stable(per_act) && $stable(cmp_act) && $stable(mode_act)));

   // R10: counter restarts after the cycle-end pulse
   p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_end_o |=> cnt_q == '0);

   // R10: pulse lasts one clock unless the next cycle is one clock long
   p_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_end_o |=> (!cyc_end_o || top_eff == '0));
endmodule

// File: tb/sim_dither_pwm.sv
module sim_dither_pwm;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   mode = 2'd0;
   logic [W-1:0] per = '0;
   logic [W-1:0] cmp = '0;
   logic         load = 1'b0;
   logic         pwm, cend;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;   // 125 MHz

   dither_pwm #(.CNT_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .per_i(per), .cmp_i(cmp),
      .load_i(load), .pwm_o(pwm), .cyc_end_o(cend)
   );

   typedef struct packed {
      logic [1:0]   m;
      logic [W-1:0] p;
      logic [W-1:0] c;
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{2'd0, 16'd9,   16'd4},
      '{2'd1, 16'd83,  16'd39},
      '{2'd2, 16'd255, 16'd96},
      '{2'd3, 16'd257, 16'd191},
      '{2'd1, 16'd48,  16'd25},
      '{2'd3, 16'd672, 16'd352},
      '{2'd2, 16'd65,  16'd48},
      '{2'd3, 16'd192, 16'd64}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic load_vals(input logic [1:0] m, input logic [W-1:0] p,
                            input logic [W-1:0] c);
      @(negedge clk);
      mode = m; per = p; cmp = c; load = 1'b1;
      @(negedge clk);
      load = 1'b0;
   endtask

   task automatic sync_end;
      while (!cend) @(negedge clk);
   endtask

   task automatic meas(output int len, output int hi);
      len = 0; hi = 0;
      do begin
         @(negedge clk);
         len++;
         if (pwm) hi++;
      end while (!cend);
   endtask

   function automatic int ext(input int m, input int d, input int c);
      int mask;
      mask = (1 << (m + 3)) - 1;
      return ((((c * d) & mask) + d) > mask) ? 1 : 0;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R10 watchdog: actual no progress expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int len, hi, n, db, pi, ci, dp, dc, ncyc, tl, th, bad;
      // R11: reset state
      repeat (3) @(negedge clk);
      chk("R11 pwm_o in reset", int'(pwm), 0);
      chk("R11 cyc_end_o in reset", int'(cend), 1);
      rst_n = 1'b1;

      // table walk: R1 R2 R3 R5 R6 R7
      foreach (VEC[i]) begin
         n    = (VEC[i].m == 0) ? 1 : (1 << (VEC[i].m + 3));
         db   = (VEC[i].m == 0) ? 0 : (VEC[i].m + 3);
         pi   = int'(VEC[i].p) >> db;
         ci   = int'(VEC[i].c) >> db;
         dp   = int'(VEC[i].p) & (n - 1);
         dc   = int'(VEC[i].c) & (n - 1);
         ncyc = (VEC[i].m == 0) ? 4 : n;
         load_vals(VEC[i].m, VEC[i].p, VEC[i].c);
         sync_end();
         tl = 0; th = 0; bad = 0;
         for (int k = 0; k < ncyc; k++) begin
            meas(len, hi);
            tl += len; th += hi;
            if (len != pi + 1) bad++;
         end
         chk($sformatf("R5 R1 R2 frame length vec %0d", i), tl, ncyc * (pi + 1) + dp * (ncyc / n));
         chk($sformatf("R6 R3 frame high vec %0d", i), th, ncyc * ci + dc * (ncyc / n));
         if (dp == 0) chk($sformatf("R7 cycles off nominal vec %0d", i), bad, 0);
      end

      // R4: per-cycle placement from index 0 after a mode change
      load_vals(2'd0, 16'd3, 16'd1);
      sync_end();
      meas(len, hi);
      load_vals(2'd1, 16'd101, 16'd32);
      sync_end();
      for (int c = 0; c < 16; c++) begin
         meas(len, hi);
         chk($sformatf("R4 R10 cycle %0d length", c), len, 7 + ext(1, 5, c));
         chk($sformatf("R6 cycle %0d high", c), hi, 2);
      end

      // R8: mode change mid-frame restarts the index
      for (int c = 0; c < 3; c++) meas(len, hi);
      load_vals(2'd2, 16'd159, 16'd0);
      sync_end();
      meas(len, hi);
      chk("R8 first cycle after mode change", len, 5);
      meas(len, hi);
      chk("R8 second cycle after mode change", len, 6);

      // R9: mid-cycle load does not disturb the running cycle
      load_vals(2'd0, 16'd20, 16'd10);
      sync_end();
      meas(len, hi);
      chk("R9 long cycle", len, 21);
      load_vals(2'd0, 16'd5, 16'd2);
      meas(len, hi);
      chk("R9 running cycle kept", len + 2, 21);
      meas(len, hi);
      chk("R9 new cycle length", len, 6);
      chk("R9 new cycle high", hi, 2);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule